// File: doc/BRIEF.md
# Sprite Attribute Table DMA Engine

This block copies a fixed-length run of bytes from system memory into sprite attribute memory. Software starts a copy by writing one byte to a control register. That byte picks a 256-byte-aligned source page. After a start-up delay, the engine moves one byte on every fourth cycle-enable tick until the whole table is filled.

The engine uses two ports. It drives a read address onto the system bus and takes the returned byte in the same cycle. It passes that byte to the sprite memory together with a write address and a write strobe. A busy output tells the rest of the system to hold off CPU accesses while the copy runs. Any control-register value above a fixed limit is stored for read-back but starts nothing.

Top module: `sdma_engine`

## Requirements
- R1: A write of a value less than or equal to 0xE0 is accepted. On the next clock `busy` is high and the destination offset is 0, so `oam_addr` reads 0xFE00.
- R2: A write of a value above 0xE0 starts nothing. When the engine is idle, `busy` stays low. When a copy is running, it continues with the same source, destination, count and timing.
- R3: During a copy, `rd_addr` equals the accepted value in bits 15:8 plus the byte index (0 for the first byte). The index rises by one after each byte.
- R4: For byte index i, the sprite memory address is 0xFE00 + i.
- R5: An accepted copy moves exactly 160 bytes. `busy` stays high until the clock edge that writes the last byte, and goes low right after it.
- R6: Only cycles with `tick` high count. Counting from the start, the first byte is written on the 11th tick, and each later byte 4 ticks after the one before it.
- R7: An accepted write while a copy runs restarts the engine. It takes the new source, destination offset 0, a full count of 160 and the full start-up delay, and no byte is written in the restart cycle.
- R8: `reg_rdata` returns the last byte written to the control register, whether or not that write was accepted.
- R9: `oam_we` is high only in a cycle that writes a byte. In that cycle `oam_data` equals `rd_data`.
- R10: While reset is asserted and after it is released, `busy` and `oam_we` are low and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Cycle-enable; only these cycles advance the engine |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data (source page) |
| reg_rdata | output | 8 | Control register read-back |
| busy | output | 1 | Copy in progress |
| rd_addr | output | 16 | System bus read address |
| rd_data | input | 8 | System bus read data, same cycle |
| oam_addr | output | 16 | Sprite memory write address |
| oam_data | output | 8 | Sprite memory write data |
| oam_we | output | 1 | Sprite memory write strobe |

## Verification
The bench times every byte in tick counts. It therefore catches a delay that is wrong by one, whether the counter starts from the wrong value or uses the wrong compare. It also catches a stride that lets bytes bunch together.

The boundary values 0xE0 and 0xE1 are both written. A design with an off-by-one limit would start on 0xE1 or ignore 0xE0. Writes are also injected in the middle of a copy. An accepted write must restart the copy from scratch. A rejected write must leave the byte stream unchanged. A design that corrupts the running copy would show a wrong address, wrong data or wrong timing. Sparse tick patterns show whether the engine counts clock cycles where it should count ticks. The 160-byte count together with the falling edge of busy catches a copy that runs one byte short or one byte long.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  parameter int unsigned SDMA_DW = 8;
  parameter int unsigned SDMA_AW = 2 * SDMA_DW;

  // control value is allowed to start a copy
  function automatic logic accept_value(input logic [SDMA_DW-1:0] v,
                                        input logic [SDMA_DW-1:0] lim);
    return v <= lim;
  endfunction

  // source address from page and byte offset
  function automatic logic [SDMA_AW-1:0] src_addr(input logic [SDMA_DW-1:0] page,
                                                  input logic [SDMA_DW-1:0] ofs);
    return {page, {SDMA_DW{1'b0}}} + {{SDMA_DW{1'b0}}, ofs};
  endfunction

  // destination address from window base and byte offset
  function automatic logic [SDMA_AW-1:0] dst_addr(input logic [SDMA_AW-1:0] base,
                                                  input logic [SDMA_DW-1:0] ofs);
    return base + {{SDMA_DW{1'b0}}, ofs};
  endfunction
endpackage

// File: rtl/sdma_ctrl_reg.sv
module sdma_ctrl_reg
  import sdma_pkg::*;
#(
  parameter logic [SDMA_DW-1:0] LIMIT = 8'hE0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [SDMA_DW-1:0] wdata,
  output logic [SDMA_DW-1:0] rdata,
  output logic [SDMA_DW-1:0] page,
  output logic               start
);
  assign start = wr && accept_value(wdata, LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      page  <= '0;
    end else begin
      if (wr)    rdata <= wdata;
      if (start) page  <= wdata;
    end
  end
endmodule

// File: rtl/sdma_pacer.sv
module sdma_pacer #(
  parameter int CW      = 5,
  parameter int LATENCY = 7,
  parameter int STRIDE  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic run,
  output logic ready
);
  localparam logic signed [CW-1:0] LOAD_V   = CW'(-LATENCY);
  localparam logic signed [CW-1:0] STRIDE_V = CW'(STRIDE);
  localparam logic signed [CW-1:0] ONE_V    = CW'(1);

  logic signed [CW-1:0] cnt_q;
  logic signed [CW-1:0] cnt_inc;

  assign cnt_inc = cnt_q + ONE_V;
  assign ready   = tick && run && (cnt_inc >= STRIDE_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= LOAD_V;
    end else if (tick && run) begin
      cnt_q <= ready ? (cnt_inc - STRIDE_V) : cnt_inc;
    end
  end
endmodule

// File: rtl/sdma_addr_gen.sv
module sdma_addr_gen #(
  parameter int OFS_W = 8,
  parameter int LEN   = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             xfer,
  output logic [OFS_W-1:0] ofs,
  output logic             busy
);
  localparam int RW = $clog2(LEN + 1);

  logic [RW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs    <= '0;
      left_q <= '0;
    end else if (start) begin
      ofs    <= '0;
      left_q <= RW'(LEN);
    end else if (xfer) begin
      ofs    <= ofs + OFS_W'(1);
      left_q <= left_q - RW'(1);
    end
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter logic [SDMA_AW-1:0] OAM_BASE = 16'hFE00,
  parameter logic [SDMA_DW-1:0] LIMIT    = 8'hE0,
  parameter int                 LEN      = 160,
  parameter int                 LATENCY  = 7,
  parameter int                 STRIDE   = 4,
  parameter int                 CW       = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               reg_wr,
  input  logic [SDMA_DW-1:0] reg_wdata,
  output logic [SDMA_DW-1:0] reg_rdata,
  output logic               busy,
  output logic [SDMA_AW-1:0] rd_addr,
  input  logic [SDMA_DW-1:0] rd_data,
  output logic [SDMA_AW-1:0] oam_addr,
  output logic [SDMA_DW-1:0] oam_data,
  output logic               oam_we
);
  localparam int OFS_W = SDMA_DW;

  // named internal events, visible to the bound checker
  logic               start_ev;
  logic               ready_ev;
  logic               xfer_ev;
  logic [SDMA_DW-1:0] page_q;
  logic [OFS_W-1:0]   ofs_q;

  sdma_ctrl_reg #(.LIMIT(LIMIT)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .page  (page_q),
    .start (start_ev)
  );

  sdma_pacer #(.CW(CW), .LATENCY(LATENCY), .STRIDE(STRIDE)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_ev),
    .tick  (tick),
    .run   (busy),
    .ready (ready_ev)
  );

  // a restart in the same cycle wins over a pending byte
  assign xfer_ev = ready_ev && !start_ev;

  sdma_addr_gen #(.OFS_W(OFS_W), .LEN(LEN)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_ev),
    .xfer  (xfer_ev),
    .ofs   (ofs_q),
    .busy  (busy)
  );

  assign rd_addr  = src_addr(page_q, ofs_q);
  assign oam_addr = dst_addr(OAM_BASE, ofs_q);
  assign oam_data = rd_data;
  assign oam_we   = xfer_ev;
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk
  import sdma_pkg::*;
#(
  parameter logic [SDMA_AW-1:0] OAM_BASE = 16'hFE00,
  parameter logic [SDMA_DW-1:0] LIMIT    = 8'hE0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [SDMA_DW-1:0] reg_wdata,
  input logic [SDMA_DW-1:0] reg_rdata,
  input logic               busy,
  input logic [SDMA_AW-1:0] rd_addr,
  input logic [SDMA_AW-1:0] oam_addr,
  input logic               start_ev,
  input logic               xfer_ev
);
  // R1
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata <= LIMIT) |=> (busy && oam_addr == OAM_BASE));

  // R2
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata > LIMIT && !busy) |=> !busy);

  // R3
  src_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_addr[SDMA_DW-1:0] == oam_addr[SDMA_DW-1:0] - OAM_BASE[SDMA_DW-1:0]));

  // R4
  dest_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ev |=> (!busy || oam_addr == $past(oam_addr) + 16'd1));

  // R5
  last_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(xfer_ev));

  // R6
  stride_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ev |=> !xfer_ev);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |-> !xfer_ev);

  // R8
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata == $past(reg_wdata)));
endmodule

bind sdma_engine sdma_engine_chk #(.OAM_BASE(OAM_BASE), .LIMIT(LIMIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .busy      (busy),
  .rd_addr   (rd_addr),
  .oam_addr  (oam_addr),
  .start_ev  (start_ev),
  .xfer_ev   (xfer_ev)
);

// File: tb/sdma_engine_tb.sv
`timescale 1ns/1ps
module sdma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        busy;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] oam_addr;
  logic [7:0]  oam_data;
  logic        oam_we;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  // system memory contents as a function of address
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rd_data = mem_byte(rd_addr);

  sdma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .oam_addr(oam_addr), .oam_data(oam_data), .oam_we(oam_we)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  // run a copy already started with page pg; optional write injected at cycle inj_at
  task automatic run_copy(input logic [7:0] pg_in, input int gap, input int inj_at,
                          input logic [7:0] inj_val);
    logic [7:0] pg = pg_in;
    int tcount = 0;
    int nb = 0;
    int last_ok = 1;
    bit done = 0;
    bit was_inj = 0;
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      @(negedge clk);
      if (was_inj) chk(reg_rdata == inj_val, "R8 readback after mid-copy write", reg_rdata, inj_val);
      was_inj = (cyc == inj_at);
      tick = (gap == 0) ? 1'b1 : (cyc % gap == 0);
      reg_wr = was_inj; reg_wdata = inj_val;
      #1;
      if (was_inj && inj_val <= 8'hE0) begin
        chk(!oam_we, "R7 no byte in restart cycle", oam_we, 0);
        tcount = 0; nb = 0; pg = inj_val;
      end else begin
        if (tick) tcount++;
        if (oam_we || (tick && nb < 160 && tcount == 11 + 4 * nb)) begin
          logic [15:0] exp_src;
          exp_src = {pg, 8'h00} + 16'(nb);
          chk(oam_we && tick && tcount == 11 + 4 * nb, "R6 byte timing",
              {oam_we, 31'(tcount)}, {1'b1, 31'(11 + 4 * nb)});
          if (oam_we) begin
            if (rd_addr != exp_src || oam_addr != 16'hFE00 + 16'(nb) ||
                oam_data != mem_byte(exp_src)) begin
              chk(0, "R3/R4/R9 addresses and data", {rd_addr, oam_addr}, {exp_src, 16'hFE00 + 16'(nb)});
            end
            nb++;
          end
        end
      end
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
      if (nb == 160) begin
        chk(!busy, "R5 busy low after last byte", busy, 0);
        done = 1;
      end else if (!busy && last_ok == 1) begin
        chk(0, "R5 busy dropped early", nb, 160);
        last_ok = 0;
        done = 1;
      end
    end
    chk(nb == 160, "R5 byte count", nb, 160);
  endtask

  // {expect accept, value}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'h00}, {1'b1, 8'hC1}, {1'b1, 8'hE0},
    {1'b0, 8'hE1}, {1'b0, 8'hFF}, {1'b1, 8'h80}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tick = 1'b1;
    #1;
    // R10 reset state
    chk(!busy, "R10 busy in reset", busy, 0);
    chk(!oam_we, "R10 oam_we in reset", oam_we, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick = 1'b0;
    #1;
    chk(reg_rdata == 8'h00, "R10 readback after reset", reg_rdata, 0);

    foreach (VEC[i]) begin
      logic acc;
      logic [7:0] v;
      acc = VEC[i][8];
      v = VEC[i][7:0];
      do_write(v);
      chk(reg_rdata == v, "R8 readback", reg_rdata, v);
      chk(busy == acc, acc ? "R1 start accepted" : "R2 start rejected", busy, acc);
      if (acc) begin
        chk(oam_addr == 16'hFE00, "R1 R4 dest offset zero", oam_addr, 16'hFE00);
        run_copy(v, i % 3, -1, 8'h00);
      end else begin
        int bad = 0;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk); tick = 1'b1; #1;
          if (oam_we || busy) bad++;
        end
        chk(bad == 0, "R2 idle after rejected value", bad, 0);
      end
    end

    // R7 restart in the middle of a copy
    do_write(8'h10);
    run_copy(8'h10, 0, 100, 8'h20);

    // R2 rejected write during a copy changes nothing
    do_write(8'h30);
    run_copy(8'h30, 0, 50, 8'hF1);

    // R7 restart on the very tick a byte would be due
    do_write(8'h44);
    run_copy(8'h44, 0, 14, 8'h55);

    // R10 reset in the middle of a copy
    do_write(8'h40);
    repeat (30) begin @(negedge clk); tick = 1'b1; end
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk(!busy && !oam_we, "R10 reset aborts copy", {busy, oam_we}, 0);
    chk(reg_rdata == 8'h00, "R10 readback cleared", reg_rdata, 0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule